// File: doc/BRIEF.md
# Leading and Trailing Bit Counter

This block counts runs of equal bits at either end of a 32-bit or 64-bit operand. It gives leading ones, leading zeros, the leading sign-bit run, trailing ones and trailing zeros. It also gives two derived values. The first is a normalisation shift amount for fixed-point scaling. The second is the sign-run count plus a signed 6-bit immediate. Every result is 32 bits wide and registered, so a result appears one clock after its operands. A second registered output carries the operand with its bit order reversed.

An encoded `op` input picks the operation. The `wide` input picks the operand width: 1 uses all 64 bits of `src`, 0 uses only `src[31:0]`. All counts come from a single priority encoder that counts leading ones. Leading-zero and sign-run counts invert the operand before it reaches the encoder. Trailing counts reverse the bit order of the operand first.

Top module: `bit_count_unit`

## Requirements
- R1: While `rst_n` is low, `cnt_q` and `rev_q` are zero. After reset, both outputs hold values computed from the inputs sampled at the previous rising clock edge.
- R2: With `op`=0, `cnt_q` is the number of consecutive ones starting at the operand's most significant bit.
- R3: With `op`=1, `cnt_q` is the number of consecutive zeros starting at the most significant bit. An all-zero operand gives 32 in 32-bit mode and 64 in 64-bit mode.
- R4: With `op`=2, `cnt_q` is the larger of the leading-ones and leading-zeros counts. It is never zero.
- R5: With `op`=3, `cnt_q` is the `op`=2 count minus one. An all-zero operand gives 0.
- R6: With `op`=4, `cnt_q` is the `op`=2 count plus `imm`, where `imm` is read as two's complement. The sum is a 32-bit two's-complement value, so it can be negative.
- R7: With `op`=5, `cnt_q` counts consecutive ones from bit 0 upward. With `op`=6, it counts consecutive zeros from bit 0 upward. An all-zero operand gives the full width for `op`=6, and an all-ones operand gives the full width for `op`=5.
- R8: With `op`=7, `cnt_q` is 0.
- R9: `rev_q` is the selected operand with its bit order reversed. In 32-bit mode, bit i of `rev_q` (i<32) is `src[31-i]`, and `rev_q[63:32]` is zero.
- R10: With `wide`=0, `src[63:32]` has no effect on either output, and no count other than `op`=4 exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 64 | Operand |
| wide | input | 1 | 1: 64-bit operand, 0: 32-bit operand in `src[31:0]` |
| op | input | 3 | Operation select (0..7 as listed in the requirements) |
| imm | input | 6 | Signed immediate for `op`=4 |
| cnt_q | output | 32 | Registered count result |
| rev_q | output | 64 | Registered bit-reversed operand |

## Verification
The assertions check these properties on every cycle:
- In 32-bit mode, counts stay at or below 32 and the upper half of the reversed word is zero.
- The sign-run count is never zero.
- The normalisation amount of a zero operand is zero.
- The unused select gives zero.
- Reset clears the result.

Exact count values need the bench's scenarios, because no cycle-local property pins them down. These include:
- runs that cross the 32-bit boundary;
- all-zero and all-ones operands in both widths;
- a negative immediate sum;
- changes to the ignored upper half of `src`.

// File: rtl/bit_count_unit.sv
module bit_count_unit #(
  parameter int WIDTH = 64,
  parameter int OUTW  = 32,
  parameter int IMMW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src,
  input  logic             wide,
  input  logic [2:0]       op,
  input  logic [IMMW-1:0]  imm,
  output logic [OUTW-1:0]  cnt_q,
  output logic [WIDTH-1:0] rev_q
);
  localparam int HALF = WIDTH / 2;
  localparam int CW   = $clog2(WIDTH) + 1;

  localparam logic [2:0] OP_LONES = 3'd0;
  localparam logic [2:0] OP_LZERO = 3'd1;
  localparam logic [2:0] OP_SIGN  = 3'd2;
  localparam logic [2:0] OP_NORM  = 3'd3;
  localparam logic [2:0] OP_SIMM  = 3'd4;
  localparam logic [2:0] OP_TONES = 3'd5;
  localparam logic [2:0] OP_TZERO = 3'd6;
  localparam logic [2:0] OP_NONE  = 3'd7;

  function automatic logic [CW-1:0] lead_ones(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n;
    logic hit;
    n   = CW'(WIDTH);
    hit = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!hit && !v[i]) begin
        n   = CW'(WIDTH - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic [WIDTH-1:0] opnd, rev_full, rev_half, rev_sel;
  logic [WIDTH-1:0] base, flipped, enc_in;
  logic [CW-1:0]    lead;
  logic             msb, trailing, invert, is_zero;
  logic [OUTW-1:0]  result;

  assign opnd = wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_rev_full
      assign rev_full[g] = src[WIDTH-1-g];
    end
    for (g = 0; g < HALF; g++) begin : g_rev_half
      assign rev_half[g] = src[HALF-1-g];
    end
  endgenerate
  assign rev_half[WIDTH-1:HALF] = '0;

  assign rev_sel  = wide ? rev_full : rev_half;
  assign msb      = wide ? src[WIDTH-1] : src[HALF-1];
  assign is_zero  = (opnd == '0);
  assign trailing = (op == OP_TONES) || (op == OP_TZERO);
  assign invert   = (op == OP_LZERO) || (op == OP_TZERO) ||
                    (((op == OP_SIGN) || (op == OP_NORM) || (op == OP_SIMM)) && !msb);

  assign base    = trailing ? rev_sel : opnd;
  assign flipped = invert ? ~base : base;
  assign enc_in  = wide ? flipped : {flipped[HALF-1:0], {HALF{1'b0}}};
  assign lead    = lead_ones(enc_in);

  always_comb begin
    case (op)
      OP_NORM: result = is_zero ? '0 : OUTW'(lead) - OUTW'(1);
      OP_SIMM: result = OUTW'(lead) + {{(OUTW-IMMW){imm[IMMW-1]}}, imm};
      OP_NONE: result = '0;
      default: result = OUTW'(lead);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rev_q <= '0;
    end else begin
      cnt_q <= result;
      rev_q <= rev_sel;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (cnt_q == '0 && rev_q == '0));

  // R10
  narrow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && op != OP_SIMM) |=> (cnt_q <= OUTW'(HALF)));

  // R9
  narrow_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> (rev_q[WIDTH-1:HALF] == '0));

  // R4
  sign_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SIGN) |=> (cnt_q != '0));

  // R5
  norm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NORM && (wide ? (src == '0) : (src[HALF-1:0] == '0))) |=> (cnt_q == '0));

  // R8
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> (cnt_q == '0));
endmodule

// File: tb/tb_bit_count_unit.sv
module tb_bit_count_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wide = 1'b0;
  logic [2:0]  op = 3'd7;
  logic [5:0]  imm = '0;
  logic [31:0] cnt_q;
  logic [63:0] rev_q;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bit_count_unit dut (.clk(clk), .rst_n(rst_n), .src(src), .wide(wide), .op(op),
                      .imm(imm), .cnt_q(cnt_q), .rev_q(rev_q));

  // {op, wide, imm, src, expected count}
  localparam int NV = 26;
  localparam logic [105:0] VEC [NV] = '{
    {3'd0, 1'b0, 6'h00, 64'hFFFF_FFFF_F000_0000, 32'd4},
    {3'd0, 1'b1, 6'h00, 64'hFFFF_FFFF_F000_0000, 32'd36},
    {3'd0, 1'b0, 6'h00, 64'h0000_0000_FFFF_FFFF, 32'd32},
    {3'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0000, 32'd32},
    {3'd1, 1'b1, 6'h00, 64'h0000_0000_0000_0000, 32'd64},
    {3'd1, 1'b1, 6'h00, 64'h0000_0000_0001_0000, 32'd47},
    {3'd1, 1'b0, 6'h00, 64'hFFFF_FFFF_0000_8000, 32'd16},
    {3'd1, 1'b1, 6'h00, 64'h8000_0000_0000_0000, 32'd0},
    {3'd2, 1'b0, 6'h00, 64'h0000_0000_FFFF_FF00, 32'd24},
    {3'd2, 1'b0, 6'h00, 64'h0000_0000_0000_0FFF, 32'd20},
    {3'd2, 1'b1, 6'h00, 64'h0000_0000_0000_0000, 32'd64},
    {3'd3, 1'b0, 6'h00, 64'hFFFF_0000_0000_0000, 32'd0},
    {3'd3, 1'b0, 6'h00, 64'h0000_0000_0000_00FF, 32'd23},
    {3'd3, 1'b1, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF, 32'd63},
    {3'd3, 1'b1, 6'h00, 64'h0000_0000_0000_0001, 32'd62},
    {3'd4, 1'b0, 6'h3D, 64'h0000_0000_0000_FFFF, 32'd13},
    {3'd4, 1'b0, 6'h3B, 64'h0000_0000_4000_0000, 32'hFFFF_FFFC},
    {3'd4, 1'b1, 6'h1F, 64'h0000_0000_0000_0000, 32'd95},
    {3'd5, 1'b0, 6'h00, 64'hFFFF_FFFF_0000_000F, 32'd4},
    {3'd5, 1'b0, 6'h00, 64'h0000_0000_FFFF_FFFF, 32'd32},
    {3'd5, 1'b1, 6'h00, 64'h0000_0000_FFFF_FFFF, 32'd32},
    {3'd5, 1'b1, 6'h00, 64'hFFFF_FFFF_FFFF_FFFF, 32'd64},
    {3'd6, 1'b0, 6'h00, 64'hABCD_0000_0000_0000, 32'd32},
    {3'd6, 1'b1, 6'h00, 64'hABCD_0000_0000_0000, 32'd48},
    {3'd6, 1'b1, 6'h00, 64'h0000_0000_0000_0000, 32'd64},
    {3'd7, 1'b1, 6'h00, 64'h0000_0000_0000_1234, 32'd0}
  };

  function automatic logic [63:0] reversed(input logic [63:0] v, input logic w);
    logic [63:0] r = '0;
    if (w) for (int i = 0; i < 64; i++) r[i] = v[63-i];
    else   for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic w, input logic [5:0] i, input logic [63:0] s);
    op = o; wide = w; imm = i; src = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    src = 64'hDEAD_BEEF_1234_5678; op = 3'd0; wide = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 cnt reset", {32'd0, cnt_q}, 64'd0);
    check("R1 rev reset", rev_q, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][105:103], VEC[k][102], VEC[k][101:96], VEC[k][95:32]);
      check(op_tag(VEC[k][105:103]), {32'd0, cnt_q}, {32'd0, VEC[k][31:0]});
      check("R9 rev", rev_q, reversed(VEC[k][95:32], VEC[k][102]));
    end

    // R10: upper half ignored in narrow mode
    apply(3'd1, 1'b0, 6'h00, 64'h0000_0000_0000_0F00);
    check("R10 clz low", {32'd0, cnt_q}, 64'd20);
    apply(3'd1, 1'b0, 6'h00, 64'hFFFF_FFFF_0000_0F00);
    check("R10 clz upper ignored", {32'd0, cnt_q}, 64'd20);
    check("R10 rev upper ignored", rev_q, 64'h0000_0000_00F0_0000);
    apply(3'd6, 1'b0, 6'h00, 64'h0000_0001_0000_0000);
    check("R10 ctz upper ignored", {32'd0, cnt_q}, 64'd32);

    // R9 single bit in both widths
    apply(3'd0, 1'b0, 6'h00, 64'h1);
    check("R9 rev narrow", rev_q, 64'h0000_0000_8000_0000);
    apply(3'd0, 1'b1, 6'h00, 64'h1);
    check("R9 rev wide", rev_q, 64'h8000_0000_0000_0000);

    // R6 most negative immediate
    apply(3'd4, 1'b0, 6'h20, 64'h0);
    check("R6 imm -32", {32'd0, cnt_q}, 64'd0);

    // R1 one-cycle latency: output holds until next edge
    op = 3'd1; wide = 1'b1; src = 64'h0;
    #1;
    check("R1 latency hold", {32'd0, cnt_q}, 64'd0);
    @(posedge clk); @(negedge clk);
    check("R1 latency update", {32'd0, cnt_q}, 64'd64);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {32'd0, cnt_q}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'd2, 1'b1, 6'h00, 64'hF000_0000_0000_0000);
    check("R4 after reset", {32'd0, cnt_q}, 64'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule